// File: doc/BRIEF.md
# Parallel DAC Bus Host Controller

This block sits on the host side of a 12-bit parallel converter bus. It drives the active-low chip-select, read/write, load and converter-reset strobes and a tri-state data bus. Commands arrive through a valid/ready handshake and come in three kinds: write (optionally followed by a load), load only, and read-back. Each nanosecond timing minimum of the converter bus is turned into a count of system clock cycles. The count is the time divided by the clock-period parameter, rounded up, and never less than one cycle.

A write drives the data and holds read/write low for the whole chip-select low window. It then keeps both in place for a hold phase after chip-select rises. When a load was asked for, the load strobe pulses only after that hold phase. A read first stops driving the bus and raises read/write for a setup phase. It then holds chip-select low for the longer of the read pulse width and the worst-case data-valid delay, and samples the bus in the last low cycle. After that it waits out the bus-float time before going idle. A separate reset request produces a minimum-width low pulse on the converter reset line.

Top module: `dacbus_host`

## Requirements
- R1: After reset the block is idle: cs_n, rw_n, ld_n and dac_rst_n are 1, bus_oe is 0, busy and rd_done are 0, and cmd_ready is 1.
- R2: cmd_ready is 1 only while the block is idle and reset_req is 0. A command is taken on a clock edge with cmd_valid and cmd_ready both 1. busy is then 1 from the next cycle until the last phase of the sequence ends, and cmd_ready stays 0 for that whole time. Op codes: 00 write, 01 write then load, 10 load only, 11 read.
- R3: On a write (op 00 or 01), cs_n is low for exactly ceil(50 ns / CLK_NS) cycles. During every one of those cycles rw_n is 0, bus_oe is 1 and bus_out equals the accepted data.
- R4: After a write's cs_n rises, rw_n stays 0, bus_oe stays 1 and bus_out stays unchanged for ceil(5 ns / CLK_NS) cycles. Op 00 keeps busy high for the chip-select phase plus this hold phase.
- R5: For op 01, ld_n goes low for ceil(50 ns / CLK_NS) cycles, and only after the write hold phase. ld_n is never low while cs_n is low.
- R6: For op 10, ld_n goes low for ceil(50 ns / CLK_NS) cycles, cs_n stays 1 and busy covers exactly that pulse.
- R7: On a read (op 11), rw_n is 1 and bus_oe is 0 for ceil(10 ns / CLK_NS) cycles before cs_n falls. cs_n then stays low for ceil(max(200, 160) ns / CLK_NS) cycles. bus_oe is 0 and rw_n is 1 for the whole read.
- R8: On a read, bus_in is sampled on the clock edge that ends the last cs_n-low cycle. The word appears on rd_data together with a single-cycle rd_done pulse, and rd_data keeps its value until the next read.
- R9: After a read's cs_n rises, busy stays 1 with bus_oe 0 for ceil(100 ns / CLK_NS) cycles.
- R10: A reset request taken while idle drives dac_rst_n low for ceil(50 ns / CLK_NS) cycles. It takes precedence over a command offered in the same cycle, which waits and is taken afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | Command kind (00 write, 01 write+load, 10 load, 11 read) |
| cmd_data | input | 12 | Word to write |
| reset_req | input | 1 | Request a converter reset pulse |
| busy | output | 1 | A sequence is in progress |
| rd_data | output | 12 | Last word read back |
| rd_done | output | 1 | One-cycle pulse when rd_data is updated |
| bus_out | output | 12 | Data driven toward the converter |
| bus_oe | output | 1 | Enable for the host bus drivers |
| bus_in | input | 12 | Data returned by the converter |
| cs_n | output | 1 | Chip-select, active low |
| rw_n | output | 1 | High for read, low for write |
| ld_n | output | 1 | Load strobe, active low |
| dac_rst_n | output | 1 | Converter reset, active low |

## Verification
The main function is exercised with a table of commands that mixes all four op codes. Writes use all-zero, all-one, mid-scale and irregular data, and each read is given a different returned word. Data that is stuck or driven at the wrong time shows up on the all-one and all-zero patterns. Per-command counts of strobe-low cycles, hold and float cycles separate one phase from another, so a wrong cycle count or a wrong phase order is caught. The bench model returns the complement of the word until late in the chip-select window, so a read that samples too early gives back the wrong value. Directed cases cover a reset request that arrives together with a command and a read-back value that must survive later writes.

// File: rtl/dacbus_pkg.sv
package dacbus_pkg;

  typedef enum logic [1:0] {
    OP_WR   = 2'b00,
    OP_WRLD = 2'b01,
    OP_LD   = 2'b10,
    OP_RD   = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WCS, ST_WHOLD, ST_LOAD, ST_RSET, ST_RCS, ST_RFLT, ST_RST
  } st_e;

  typedef struct packed {
    logic cs_n;
    logic rw_n;
    logic ld_n;
    logic rst_n;
    logic oe;
  } strobe_t;

  localparam strobe_t STRB_IDLE = '{cs_n: 1'b1, rw_n: 1'b1, ld_n: 1'b1, rst_n: 1'b1, oe: 1'b0};

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacbus_timer.sv
module dacbus_timer #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R2: each phase starts from the length requested for it
  assert_timer_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/dacbus_seq.sv
module dacbus_seq
  import dacbus_pkg::*;
#(
  parameter int unsigned CW     = 5,
  parameter int unsigned C_WCS  = 5,
  parameter int unsigned C_HOLD = 1,
  parameter int unsigned C_LWD  = 5,
  parameter int unsigned C_RDS  = 1,
  parameter int unsigned C_RCS  = 20,
  parameter int unsigned C_DZ   = 10,
  parameter int unsigned C_RST  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          reset_req,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          cmd_ready,
  output logic          busy,
  output logic          accept,
  output logic          capture,
  output strobe_t       strb
);

  st_e     state_q, state_d;
  logic    ldp_q, ldp_d;
  strobe_t strb_q, strb_d;
  op_e     op;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = (state_q == ST_IDLE) && !reset_req;
  assign accept    = cmd_valid && cmd_ready;
  assign busy      = (state_q != ST_IDLE);
  assign strb      = strb_q;

  function automatic strobe_t decode(input st_e s);
    strobe_t o;
    o = STRB_IDLE;
    case (s)
      ST_WCS:   begin o.cs_n = 1'b0; o.rw_n = 1'b0; o.oe = 1'b1; end
      ST_WHOLD: begin o.rw_n = 1'b0; o.oe = 1'b1; end
      ST_LOAD:  o.ld_n  = 1'b0;
      ST_RCS:   o.cs_n  = 1'b0;
      ST_RST:   o.rst_n = 1'b0;
      default:  ;
    endcase
    return o;
  endfunction

  always_comb begin
    state_d = state_q;
    ldp_d   = ldp_q;
    tmr_val = '0;
    capture = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (reset_req) begin
          state_d = ST_RST;   tmr_val = CW'(C_RST - 1);
        end else if (accept) begin
          ldp_d = (op == OP_WRLD);
          case (op)
            OP_WR, OP_WRLD: begin state_d = ST_WCS;  tmr_val = CW'(C_WCS - 1); end
            OP_LD:          begin state_d = ST_LOAD; tmr_val = CW'(C_LWD - 1); end
            default:        begin state_d = ST_RSET; tmr_val = CW'(C_RDS - 1); end
          endcase
        end
      end
      ST_WCS:   if (tmr_done) begin state_d = ST_WHOLD; tmr_val = CW'(C_HOLD - 1); end
      ST_WHOLD: if (tmr_done) begin
        if (ldp_q) begin state_d = ST_LOAD; tmr_val = CW'(C_LWD - 1); end
        else       state_d = ST_IDLE;
      end
      ST_LOAD:  if (tmr_done) state_d = ST_IDLE;
      ST_RSET:  if (tmr_done) begin state_d = ST_RCS; tmr_val = CW'(C_RCS - 1); end
      ST_RCS:   if (tmr_done) begin
        state_d = ST_RFLT; tmr_val = CW'(C_DZ - 1); capture = 1'b1;
      end
      ST_RFLT:  if (tmr_done) state_d = ST_IDLE;
      ST_RST:   if (tmr_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    tmr_load = (state_d != state_q);
    strb_d   = decode(state_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ldp_q   <= 1'b0;
      strb_q  <= STRB_IDLE;
    end else begin
      state_q <= state_d;
      ldp_q   <= ldp_d;
      strb_q  <= strb_d;
    end
  end

  // R5: the load strobe never overlaps a chip-select window
  assert_no_load_in_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!strb_q.cs_n && !strb_q.ld_n));
  // R2: a taken command makes the block busy and closes the handshake
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !cmd_ready));
  // R4: when a write's chip-select rises, read/write is still low
  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(strb_q.cs_n) && strb_q.oe) |-> !strb_q.rw_n);
  // R8: the capture edge ends a read chip-select window
  assert_capture_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!strb_q.cs_n && strb_q.rw_n && !strb_q.oe) ##1 strb_q.cs_n);
  // R10: the converter reset pulse is part of a busy sequence
  assert_dac_rst_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_q.rst_n |-> busy);

endmodule

// File: rtl/dacbus_capture.sv
module dacbus_capture #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] rd_data,
  output logic          rd_done
);

  logic [DW-1:0] word_q, word_d;
  logic          done_q;

  always_comb begin
    word_d = word_q;
    if (cap) word_d = bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      word_q <= word_d;
      done_q <= cap;
    end
  end

  assign rd_data = word_q;
  assign rd_done = done_q;

  // R8: the read word changes only on a capture edge
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(word_q));
  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/dacbus_host.sv
module dacbus_host
  import dacbus_pkg::*;
#(
  parameter int unsigned DW       = 12,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned WCS_NS   = 50,
  parameter int unsigned HOLD_NS  = 5,
  parameter int unsigned LWD_NS   = 50,
  parameter int unsigned RDS_NS   = 10,
  parameter int unsigned RCS_NS   = 200,
  parameter int unsigned VALID_NS = 160,
  parameter int unsigned FLOAT_NS = 100,
  parameter int unsigned RST_NS   = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  input  logic          reset_req,
  output logic          busy,
  output logic [DW-1:0] rd_data,
  output logic          rd_done,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_in,
  output logic          cs_n,
  output logic          rw_n,
  output logic          ld_n,
  output logic          dac_rst_n
);

  localparam int unsigned C_WCS  = ns2cyc(WCS_NS, CLK_NS);
  localparam int unsigned C_HOLD = ns2cyc(HOLD_NS, CLK_NS);
  localparam int unsigned C_LWD  = ns2cyc(LWD_NS, CLK_NS);
  localparam int unsigned C_RDS  = ns2cyc(RDS_NS, CLK_NS);
  localparam int unsigned C_RCS  = ns2cyc(umax(RCS_NS, VALID_NS), CLK_NS);
  localparam int unsigned C_DZ   = ns2cyc(FLOAT_NS, CLK_NS);
  localparam int unsigned C_RST  = ns2cyc(RST_NS, CLK_NS);
  localparam int unsigned C_MAX  = umax(umax(umax(C_WCS, C_HOLD), umax(C_LWD, C_RDS)),
                                        umax(umax(C_RCS, C_DZ), C_RST));
  localparam int unsigned CW     = $clog2(C_MAX + 1);

  logic          rs1_q, rs2_q, srst_n;
  logic          tmr_load, tmr_done, accept, capture;
  logic [CW-1:0] tmr_val;
  logic [DW-1:0] wdata_q, wdata_d;
  strobe_t       strb;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign srst_n = rs2_q;

  always_comb begin
    wdata_d = wdata_q;
    if (accept && (cmd_op[1] == 1'b0)) wdata_d = cmd_data;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) wdata_q <= '0;
    else         wdata_q <= wdata_d;
  end

  dacbus_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(srst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  dacbus_seq #(
    .CW(CW), .C_WCS(C_WCS), .C_HOLD(C_HOLD), .C_LWD(C_LWD), .C_RDS(C_RDS),
    .C_RCS(C_RCS), .C_DZ(C_DZ), .C_RST(C_RST)
  ) u_seq (
    .clk(clk), .rst_n(srst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .reset_req(reset_req), .tmr_done(tmr_done), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .cmd_ready(cmd_ready), .busy(busy), .accept(accept),
    .capture(capture), .strb(strb)
  );

  dacbus_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(srst_n), .cap(capture), .bus_in(bus_in),
    .rd_data(rd_data), .rd_done(rd_done)
  );

  assign bus_out   = wdata_q;
  assign bus_oe    = strb.oe;
  assign cs_n      = strb.cs_n;
  assign rw_n      = strb.rw_n;
  assign ld_n      = strb.ld_n;
  assign dac_rst_n = strb.rst_n;

  // R3: the driven word does not change while a write chip-select is low
  assert_wr_data_stable_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(bus_out));

endmodule

// File: tb/dacbus_host_test.sv
`timescale 1ns/1ps
module dacbus_host_test;

  localparam int CLK_PERIOD = 10;
  localparam int E_WCS  = 5;
  localparam int E_HOLD = 1;
  localparam int E_LWD  = 5;
  localparam int E_RDS  = 1;
  localparam int E_RCS  = 20;
  localparam int E_DZ   = 10;
  localparam int E_RST  = 5;

  // {op[25:24], write data[23:12], returned word[11:0]}
  localparam logic [25:0] VEC [8] = '{
    {2'b00, 12'h5A3, 12'h000},
    {2'b01, 12'hFFF, 12'h000},
    {2'b11, 12'h000, 12'hA5C},
    {2'b10, 12'h000, 12'h000},
    {2'b00, 12'h000, 12'h000},
    {2'b11, 12'h000, 12'h001},
    {2'b01, 12'h800, 12'h000},
    {2'b11, 12'h000, 12'hFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, reset_req;
  logic [1:0]  cmd_op;
  logic [11:0] cmd_data, bus_in, rd_data, bus_out, rd_val;
  logic        cmd_ready, busy, rd_done, bus_oe, cs_n, rw_n, ld_n, dac_rst_n;
  int          lo_cnt;
  int          tests = 0, fails = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacbus_host #(.CLK_NS(CLK_PERIOD)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .reset_req(reset_req), .busy(busy),
    .rd_data(rd_data), .rd_done(rd_done), .bus_out(bus_out), .bus_oe(bus_oe),
    .bus_in(bus_in), .cs_n(cs_n), .rw_n(rw_n), .ld_n(ld_n), .dac_rst_n(dac_rst_n)
  );

  // converter model: the word is valid only late in the chip-select window
  always @(posedge clk) lo_cnt <= cs_n ? 0 : lo_cnt + 1;
  assign bus_in = (lo_cnt >= 15) ? rd_val : ~rd_val;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d (0x%0h), expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  int n_busy, n_cs, n_ld, n_rst, n_done, n_bad, n_pre, n_post, n_hold, n_rdy;
  logic [11:0] done_word;

  // called at the negedge just after the accepting edge
  task automatic watch(input logic [1:0] op, input logic [11:0] d);
    bit seen_cs = 0;
    n_busy = 0; n_cs = 0; n_ld = 0; n_rst = 0; n_done = 0; n_bad = 0;
    n_pre = 0; n_post = 0; n_hold = 0; n_rdy = 0; done_word = '0;
    for (int i = 0; i < 200; i++) begin
      if (!busy) break;
      n_busy++;
      if (cmd_ready) n_rdy++;
      if (!cs_n) begin
        n_cs++; seen_cs = 1;
        if (op[1] == 1'b0 && (rw_n || !bus_oe || bus_out != d)) n_bad++;
      end else if (seen_cs) begin
        n_post++;
        if (op[1] == 1'b0 && ld_n && !rw_n && bus_oe && bus_out == d) n_hold++;
      end else if (rw_n && !bus_oe) n_pre++;
      if (op == 2'b11 && (bus_oe || !rw_n)) n_bad++;
      if (!ld_n) begin n_ld++; if (!cs_n) n_bad++; end
      if (!dac_rst_n) n_rst++;
      if (rd_done) begin n_done++; done_word = rd_data; end
      @(negedge clk);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [11:0] d);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: got %0d cycles, expected fewer", 100000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] keep;
    rst_n = 1'b0; cmd_valid = 1'b0; reset_req = 1'b0; cmd_op = '0; cmd_data = '0; rd_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 idle state after reset
    check(cs_n && rw_n && ld_n && dac_rst_n, "R1 strobes high", {cs_n, rw_n, ld_n, dac_rst_n}, 15);
    check(!bus_oe && !busy && !rd_done, "R1 idle outputs", {bus_oe, busy, rd_done}, 0);
    check(cmd_ready, "R1 ready", cmd_ready, 1);

    for (int v = 0; v < 8; v++) begin
      logic [1:0]  op;
      logic [11:0] d;
      op = VEC[v][25:24]; d = VEC[v][23:12]; rd_val = VEC[v][11:0];
      issue(op, d);
      watch(op, d);
      check(n_rdy == 0, "R2 ready low while busy", n_rdy, 0);
      check(n_bad == 0, "R3/R5/R7 strobe or data violation", n_bad, 0);
      case (op)
        2'b00, 2'b01: begin
          check(n_cs == E_WCS, "R3 write cs low cycles", n_cs, E_WCS);
          check(n_hold == E_HOLD, "R4 write hold cycles", n_hold, E_HOLD);
          if (op == 2'b00)
            check(n_busy == E_WCS + E_HOLD, "R4 write busy", n_busy, E_WCS + E_HOLD);
          else begin
            check(n_ld == E_LWD, "R5 load width", n_ld, E_LWD);
            check(n_busy == E_WCS + E_HOLD + E_LWD, "R5 write+load busy", n_busy, E_WCS + E_HOLD + E_LWD);
          end
        end
        2'b10: begin
          check(n_ld == E_LWD, "R6 load width", n_ld, E_LWD);
          check(n_cs == 0, "R6 no chip-select", n_cs, 0);
          check(n_busy == E_LWD, "R6 busy", n_busy, E_LWD);
        end
        default: begin
          check(n_pre == E_RDS, "R7 read setup", n_pre, E_RDS);
          check(n_cs == E_RCS, "R7 read cs low cycles", n_cs, E_RCS);
          check(n_post == E_DZ, "R9 float cycles", n_post, E_DZ);
          check(n_done == 1, "R8 one done pulse", n_done, 1);
          check(done_word == rd_val, "R8 read word", done_word, rd_val);
        end
      endcase
    end

    // R8: the read word survives a later write and load
    keep = rd_data;
    issue(2'b01, 12'h3C3);
    watch(2'b01, 12'h3C3);
    check(rd_data == keep, "R8 rd_data held", rd_data, keep);

    // R10: reset request wins over a command offered in the same cycle
    reset_req = 1'b1; cmd_valid = 1'b1; cmd_op = 2'b00; cmd_data = 12'h123;
    #1;
    check(!cmd_ready, "R10 ready low under reset request", cmd_ready, 0);
    @(negedge clk);
    reset_req = 1'b0;
    watch(2'b00, 12'h123);
    check(n_rst == E_RST, "R10 reset pulse width", n_rst, E_RST);
    check(n_cs == 0, "R10 no write during reset", n_cs, 0);
    check(n_busy == E_RST, "R10 reset busy", n_busy, E_RST);
    // the waiting write is taken next
    @(negedge clk);
    cmd_valid = 1'b0;
    watch(2'b00, 12'h123);
    check(n_cs == E_WCS, "R10 deferred write performed", n_cs, E_WCS);
    check(n_hold == E_HOLD, "R4 deferred write hold", n_hold, E_HOLD);
    check(!busy && cmd_ready, "R2 idle again", {busy, cmd_ready}, 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule